// File: doc/BRIEF.md
# Top-of-Hour Chime Generator

This block sounds a short countdown on a buzzer as each hour ends. It reads the running time as four BCD digits: minutes tens, minutes units, seconds tens and seconds units. In the last minute of the hour it gives three low beeps two seconds apart, then one high beep in the final second. The two pitches come in as free-running square-wave levels, nominally 500 Hz and 1 kHz. The block only decides which of the two levels, if either, reaches the buzzer pin.

The decode runs on the system clock. A first register stage latches which kind of beep the present time calls for. A second register stage gates the chosen tone level onto the buzzer, so the pin is glitch-free. Parameters set the digit width, the minute in which the chime plays, the second of the final high beep, how many low beeps come before it, and the spacing between beeps.

Top module: `hour_chime`

## Requirements
- R1: While rst_n is low at a clock edge, buzz is low after that edge. Directly after reset is released, buzz stays low for one more edge.
- R2: Whenever the minutes digits do not read 5 (tens) and 9 (units), buzz stays low for every tone input.
- R3: At 59 minutes with seconds 53, 55 or 57, buzz copies the low-tone input tone_lo. The high-tone input has no effect.
- R4: At 59 minutes 59 seconds, buzz copies the high-tone input tone_hi. The low-tone input has no effect.
- R5: At 59 minutes with any other seconds value (0 to 52, 54, 56 and 58), buzz stays low.
- R6: A new time value reaches buzz on the second clock edge after it is applied. A change of tone level reaches buzz on the first edge.
- R7: For as long as a beep second is shown, buzz keeps tracking its tone for every clock of that interval. A beep does not stop early.
- R8: A digit outside 0 to 9 never matches. For example, seconds units 0xB, 0xD or 0xF at 59:5x, or minutes units 0xF, keep buzz low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| min_tens | input | DIGIT_W | Minutes tens digit, BCD |
| min_units | input | DIGIT_W | Minutes units digit, BCD |
| sec_tens | input | DIGIT_W | Seconds tens digit, BCD |
| sec_units | input | DIGIT_W | Seconds units digit, BCD |
| tone_lo | input | 1 | Low-pitch square-wave level |
| tone_hi | input | 1 | High-pitch square-wave level |
| buzz | output | 1 | Buzzer drive |

## Verification
A time change takes two clock edges to reach buzz: one through the beep-kind register and one through the output register. A tone change takes one edge. For each time in the sweep, the bench holds the new time for two edges before it makes any check. It then applies each of the four tone combinations and samples buzz one edge after each. A separate sequence samples buzz on the first and on the second edge after a time change, to confirm the two-edge delay exactly. A similar sequence covers the first edges after reset is released.

// File: rtl/chime_pkg.sv
// Shared types for the top-of-hour chime.
// Assumes: only one beep kind is active at any time.
package chime_pkg;
    typedef enum logic [1:0] {
        BEEP_NONE = 2'd0,
        BEEP_LOW  = 2'd1,
        BEEP_HIGH = 2'd2
    } beep_e;
endpackage

// File: rtl/chime_match.sv
// Decodes the BCD time into the kind of beep due and registers it.
// Assumes: digits are BCD, and a non-decimal code must simply fail to match.
// The low-beep seconds are derived from FINAL_SEC, GAP and NUM_LOW.
module chime_match
    import chime_pkg::*;
#(
    parameter int DIGIT_W   = 4,
    parameter int FINAL_MIN = 59,
    parameter int FINAL_SEC = 59,
    parameter int NUM_LOW   = 3,
    parameter int GAP       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] min_tens,
    input  logic [DIGIT_W-1:0] min_units,
    input  logic [DIGIT_W-1:0] sec_tens,
    input  logic [DIGIT_W-1:0] sec_units,
    output beep_e              kind_q
);
    localparam logic [DIGIT_W-1:0] MIN_T = DIGIT_W'(FINAL_MIN / 10);
    localparam logic [DIGIT_W-1:0] MIN_U = DIGIT_W'(FINAL_MIN % 10);
    localparam logic [DIGIT_W-1:0] HI_T  = DIGIT_W'(FINAL_SEC / 10);
    localparam logic [DIGIT_W-1:0] HI_U  = DIGIT_W'(FINAL_SEC % 10);

    logic               in_min;
    logic               high_hit;
    logic [NUM_LOW-1:0] low_hit;
    beep_e              kind_d;

    assign in_min   = (min_tens == MIN_T) && (min_units == MIN_U);
    assign high_hit = (sec_tens == HI_T) && (sec_units == HI_U);

    // One comparator per low-beep second, spaced GAP seconds back from the high beep.
    for (genvar i = 0; i < NUM_LOW; i++) begin : g_low
        localparam int SEC = FINAL_SEC - GAP * (i + 1);
        assign low_hit[i] = (sec_tens == DIGIT_W'(SEC / 10)) &&
                            (sec_units == DIGIT_W'(SEC % 10));
    end

    // Picks the beep kind for the present time.
    always_comb begin
        kind_d = BEEP_NONE;
        if (in_min && high_hit)
            kind_d = BEEP_HIGH;
        else if (in_min && (|low_hit))
            kind_d = BEEP_LOW;
    end

    // Registers the beep kind, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind_q <= BEEP_NONE;
        else
            kind_q <= kind_d;
    end

    assert_kind_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q != beep_e'(2'b11));
    assert_quiet_minute_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_min |=> kind_q == BEEP_NONE);
endmodule

// File: rtl/chime_tone_gate.sv
// Gates the selected tone level onto a registered buzzer output.
// Assumes: the tone inputs are square-wave levels synchronous to clk.
module chime_tone_gate
    import chime_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  beep_e kind,
    input  logic  tone_lo,
    input  logic  tone_hi,
    output logic  buzz
);
    logic buzz_d;

    // Chooses the tone level for the current beep kind.
    always_comb begin
        unique case (kind)
            BEEP_LOW:  buzz_d = tone_lo;
            BEEP_HIGH: buzz_d = tone_hi;
            default:   buzz_d = 1'b0;
        endcase
    end

    // Output flop, so the buzzer pin never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buzz <= 1'b0;
        else
            buzz <= buzz_d;
    end

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kind == BEEP_NONE |=> !buzz);
    assert_low_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kind == BEEP_LOW |=> buzz == $past(tone_lo));
    assert_high_tone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kind == BEEP_HIGH |=> buzz == $past(tone_hi));
endmodule

// File: rtl/hour_chime.sv
// Top-of-hour chime: plays low beeps and then a final high beep late in the hour.
// Assumes: BCD time digits and tone levels are synchronous to clk.
// Latency is two edges from time to buzz and one edge from tone to buzz.
module hour_chime #(
    parameter int DIGIT_W   = 4,
    parameter int FINAL_MIN = 59,
    parameter int FINAL_SEC = 59,
    parameter int NUM_LOW   = 3,
    parameter int GAP       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] min_tens,
    input  logic [DIGIT_W-1:0] min_units,
    input  logic [DIGIT_W-1:0] sec_tens,
    input  logic [DIGIT_W-1:0] sec_units,
    input  logic               tone_lo,
    input  logic               tone_hi,
    output logic               buzz
);
    import chime_pkg::*;

    beep_e kind_q;
    logic  at_min;

    chime_match #(
        .DIGIT_W  (DIGIT_W),
        .FINAL_MIN(FINAL_MIN),
        .FINAL_SEC(FINAL_SEC),
        .NUM_LOW  (NUM_LOW),
        .GAP      (GAP)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .min_tens (min_tens),
        .min_units(min_units),
        .sec_tens (sec_tens),
        .sec_units(sec_units),
        .kind_q   (kind_q)
    );

    chime_tone_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind_q),
        .tone_lo(tone_lo),
        .tone_hi(tone_hi),
        .buzz   (buzz)
    );

    // Port-level view of the chime minute, used only by the checks below.
    assign at_min = (min_tens == DIGIT_W'(FINAL_MIN / 10)) &&
                    (min_units == DIGIT_W'(FINAL_MIN % 10));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !buzz);
    assert_two_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(at_min, 2) |-> !buzz);
endmodule

// File: tb/hour_chime_tb.sv
module hour_chime_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] min_tens = '0, min_units = '0, sec_tens = '0, sec_units = '0;
    logic       tone_lo = 1'b0, tone_hi = 1'b0;
    logic       buzz;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    hour_chime u_dut (
        .clk(clk), .rst_n(rst_n),
        .min_tens(min_tens), .min_units(min_units),
        .sec_tens(sec_tens), .sec_units(sec_units),
        .tone_lo(tone_lo), .tone_hi(tone_hi),
        .buzz(buzz)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_time(input logic [3:0] mt, mu, st, su);
        min_tens = mt; min_units = mu; sec_tens = st; sec_units = su;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (buzz !== exp) begin
            fails++;
            $display("FAIL %s at %h%h:%h%h lo=%b hi=%b: buzz=%b expected=%b",
                     req, min_tens, min_units, sec_tens, sec_units,
                     tone_lo, tone_hi, buzz, exp);
        end
    endtask

    // Beep kind from the requirements: 0 none, 1 low, 2 high.
    function automatic int exp_kind(input int m, input int s);
        if (m != 59) return 0;            // R2
        if (s == 59) return 2;            // R4
        if (s == 53 || s == 55 || s == 57) return 1; // R3
        return 0;                         // R5
    endfunction

    initial begin
        // R1: reset holds buzz low even while a beep is due
        set_time(4'd5, 4'd9, 4'd5, 4'd3);
        tone_lo = 1'b1; tone_hi = 1'b1;
        repeat (3) tick();
        check("R1", 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1", 1'b0);
        tick();
        check("R6", 1'b1);

        // R6: time reaches buzz exactly on the second edge
        set_time(4'd5, 4'd9, 4'd5, 4'd2);
        tone_hi = 1'b0;
        repeat (3) tick();
        check("R6", 1'b0);
        set_time(4'd5, 4'd9, 4'd5, 4'd3);
        tick(); check("R6", 1'b0);
        tick(); check("R6", 1'b1);
        set_time(4'd5, 4'd9, 4'd5, 4'd4);
        tick(); check("R6", 1'b1);
        tick(); check("R6", 1'b0);

        // R7: tone followed on every clock while the beep second is held
        set_time(4'd5, 4'd5 + 4'd4, 4'd5, 4'd7);
        tone_hi = 1'b0;
        tick(); tick();
        for (int k = 0; k < 20; k++) begin
            tone_lo = k[0];
            tick();
            check("R7", k[0]);
        end

        // R8: non-decimal digits never match
        tone_lo = 1'b1; tone_hi = 1'b1;
        set_time(4'd5, 4'd9, 4'd5, 4'hB); repeat (3) tick(); check("R8", 1'b0);
        set_time(4'd5, 4'd9, 4'd5, 4'hD); repeat (3) tick(); check("R8", 1'b0);
        set_time(4'd5, 4'd9, 4'd5, 4'hF); repeat (3) tick(); check("R8", 1'b0);
        set_time(4'd5, 4'hF, 4'd5, 4'd9); repeat (3) tick(); check("R8", 1'b0);
        set_time(4'd5, 4'd9, 4'hD, 4'd9); repeat (3) tick(); check("R8", 1'b0);

        // R2 R3 R4 R5 R7: exhaustive sweep of every minute and second
        for (int m = 0; m < 60; m++) begin
            for (int s = 0; s < 60; s++) begin
                int kind;
                kind = exp_kind(m, s);
                set_time(4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10));
                tone_lo = 1'b0; tone_hi = 1'b0;
                tick(); tick();
                for (int p = 0; p < 4; p++) begin
                    logic e;
                    tone_lo = p[0]; tone_hi = p[1];
                    tick();
                    e = (kind == 1) ? p[0] : (kind == 2) ? p[1] : 1'b0;
                    if (m != 59)      check("R2", e);
                    else if (kind == 1) check("R3", e);
                    else if (kind == 2) check("R4", e);
                    else                check("R5", e);
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule